// File: doc/BRIEF.md
# Interrupt Vector Target Cache

This block lowers the latency of interrupt entry. Normally the fetch unit first reads the vector-table word and decodes the branch stored there before it can go to the handler. Here the final handler address is kept in a small cache, so fetch can go to the handler directly. There are four fixed entries, one for each combination of interrupt kind (normal or fast) and target privilege level (lower or hypervisor).

An entry is filled from the allocation port. That port fires when a vector fetch completes and carries:
- the vector address,
- the fetched instruction word,
- a flag that says the address is in tightly-coupled memory.

Only an unconditional immediate branch read from tightly-coupled memory is cached. Its target is computed once, at allocation. The lookup port answers combinationally in the cycle of the request.

A disable bit and a global invalidate both drop every entry. The contents are architecturally invisible, so nothing needs to be flushed on a context switch.

Top module: `irq_vec_cache`

## Requirements
- R1: Only exception types 2'b01 (normal interrupt) and 2'b10 (fast interrupt) can hit or allocate. Types 2'b00 and 2'b11 always miss on lookup, and an allocation with those types changes no entry.
- R2: A lookup hits only when `lk_in_tcm` is 1. An interrupt allocation with `al_in_tcm` at 0 leaves its entry invalid.
- R3: An instruction is compatible only when bits [31:28] are 4'hE and bits [27:24] are 4'hA. A normal or fast interrupt allocation with an incompatible word leaves its entry invalid.
- R4: The stored target is the vector address plus 8 plus the sign-extended bits [23:0] shifted left by 2, computed modulo 2^32.
- R5: There are four independent entries, selected by {type is fast, `hyp` bit}. A hit needs a valid entry that matches both the kind and the level. An allocation to one entry leaves the other three unchanged.
- R6: `lk_hit` and `lk_target` respond in the same cycle as `lk_valid`. An allocation made in that same cycle becomes visible only from the next cycle.
- R7: After a synchronous reset all entries are invalid and the cache is enabled, so allocation works with `cfg_disable` at 0.
- R8: While `cfg_disable` is 1:
  - no lookup hits;
  - no allocation takes effect;
  - all entries are cleared, so nothing hits after re-enable until it is allocated again.
- R9: `inv_all` clears all four entries in one cycle. An allocation presented in the same cycle is dropped.
- R10: On a miss, `lk_target` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_disable | input | 1 | 1 suppresses hits and allocations and clears all entries |
| inv_all | input | 1 | Clears all entries |
| lk_valid | input | 1 | Lookup request |
| lk_type | input | 2 | Exception type of the lookup (01 normal, 10 fast) |
| lk_hyp | input | 1 | Target level of the lookup: 1 hypervisor, 0 lower |
| lk_in_tcm | input | 1 | Vector of the lookup lies in tightly-coupled memory |
| lk_hit | output | 1 | Lookup hit |
| lk_target | output | 32 | Cached handler address, zero on a miss |
| al_valid | input | 1 | Completed vector fetch |
| al_type | input | 2 | Exception type of the fetched vector |
| al_hyp | input | 1 | Target level of the fetched vector |
| al_vaddr | input | 32 | Vector address |
| al_instr | input | 32 | Fetched instruction word |
| al_in_tcm | input | 1 | Vector address lies in tightly-coupled memory |

## Verification
Allocations are driven with forward offsets, backward offsets and an address that wraps past 2^32, to separate a correct sign extension and shift from near misses. Each entry is then probed with all four kind/level pairs, which exposes index swaps that a single entry would hide.

Incompatible words are tried in two forms, each catching one half of the compatibility check:
- a conditional branch;
- a branch-with-link pattern.

Lookups in the same cycle as an allocation, invalidate or disable separate the old state from the new one. A long run of biased random traffic is also compared cycle by cycle against a behavioural model.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam logic [1:0] KIND_NORM = 2'b01;
  localparam logic [1:0] KIND_FAST = 2'b10;

  function automatic logic is_intr(input logic [1:0] kind);
    return (kind == KIND_NORM) || (kind == KIND_FAST);
  endfunction

  // entry index = {fast, hypervisor}
  function automatic logic [1:0] slot_of(input logic [1:0] kind, input logic hyp);
    return {kind == KIND_FAST, hyp};
  endfunction
endpackage

// File: rtl/ivc_branch_decode.sv
module ivc_branch_decode #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 24,
  parameter int PC_OFS = 8
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [31:0]       instr,
  output logic              compat,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    compat = (instr[31:28] == 4'hE) && (instr[27:24] == 4'hA);
    offset = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00};
    target = vaddr + ADDR_W'(PC_OFS) + offset;
  end
endmodule

// File: rtl/ivc_entry_store.sv
module ivc_entry_store #(
  parameter int DATA_W = 32,
  parameter int N_ENT  = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [N_ENT-1:0]  vld;
  logic [DATA_W-1:0] mem [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst || clr_all)
        vld[i] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        vld[i] <= wr_ok;
    end
  end

  // data array without reset; valid bits guard it
  always_ff @(posedge clk) begin
    if (wr_en && wr_ok && !clr_all)
      mem[wr_idx] <= wr_data;
  end

  assign rd_valid = vld[rd_idx];
  assign rd_data  = mem[rd_idx];
endmodule

// File: rtl/irq_vec_cache.sv
module irq_vec_cache
  import ivc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_ENT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_disable,
  input  logic              inv_all,
  input  logic              lk_valid,
  input  logic [1:0]        lk_type,
  input  logic              lk_hyp,
  input  logic              lk_in_tcm,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              al_valid,
  input  logic [1:0]        al_type,
  input  logic              al_hyp,
  input  logic [ADDR_W-1:0] al_vaddr,
  input  logic [31:0]       al_instr,
  input  logic              al_in_tcm
);
  localparam int IDX_W = $clog2(N_ENT);

  logic              br_ok;
  logic [ADDR_W-1:0] br_tgt;
  logic              wr_en, clr_all;
  logic              rd_valid;
  logic [ADDR_W-1:0] rd_data;

  ivc_branch_decode #(.ADDR_W(ADDR_W)) u_dec (
    .vaddr (al_vaddr),
    .instr (al_instr),
    .compat(br_ok),
    .target(br_tgt)
  );

  assign clr_all = inv_all | cfg_disable;
  assign wr_en   = al_valid & is_intr(al_type);

  ivc_entry_store #(.DATA_W(ADDR_W), .N_ENT(N_ENT)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr_all (clr_all),
    .wr_en   (wr_en),
    .wr_idx  (IDX_W'(slot_of(al_type, al_hyp))),
    .wr_ok   (br_ok & al_in_tcm),
    .wr_data (br_tgt),
    .rd_idx  (IDX_W'(slot_of(lk_type, lk_hyp))),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  always_comb begin
    lk_hit    = lk_valid & ~cfg_disable & is_intr(lk_type) & lk_in_tcm & rd_valid;
    lk_target = lk_hit ? rd_data : '0;
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_disable,
  input logic              inv_all,
  input logic              lk_valid,
  input logic [1:0]        lk_type,
  input logic              lk_hyp,
  input logic              lk_in_tcm,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_target,
  input logic              al_valid,
  input logic [1:0]        al_type,
  input logic              al_hyp,
  input logic [ADDR_W-1:0] al_vaddr,
  input logic [31:0]       al_instr,
  input logic              al_in_tcm
);
  assert_other_type_miss_R1: assert property (@(posedge clk) disable iff (rst)
    (lk_type == 2'b00 || lk_type == 2'b11) |-> !lk_hit);

  assert_non_tcm_miss_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_in_tcm |-> !lk_hit);

  assert_after_disable_miss_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_disable |=> !lk_hit);

  assert_after_inval_miss_R9: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !lk_hit);

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_target == '0));
endmodule

bind irq_vec_cache ivc_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_vec_cache_test.sv
`timescale 1ns/1ps
module irq_vec_cache_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_disable = 1'b0, inv_all = 1'b0;
  logic        lk_valid = 1'b0, lk_hyp = 1'b0, lk_in_tcm = 1'b0;
  logic [1:0]  lk_type = 2'b00;
  logic        lk_hit;
  logic [31:0] lk_target;
  logic        al_valid = 1'b0, al_hyp = 1'b0, al_in_tcm = 1'b0;
  logic [1:0]  al_type = 2'b00;
  logic [31:0] al_vaddr = '0, al_instr = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_vld [4];
  logic [31:0] m_tgt [4];

  always #2 clk = ~clk;

  irq_vec_cache uut (.*);

  function automatic int slot(input logic [1:0] t, input logic h);
    return (t == 2'b10 ? 2 : 0) + (h ? 1 : 0);
  endfunction

  function automatic bit intr(input logic [1:0] t);
    return t == 2'b01 || t == 2'b10;
  endfunction

  task automatic check(input string tag);
    bit exp_hit;
    logic [31:0] exp_tgt;
    exp_hit = lk_valid && !cfg_disable && intr(lk_type) && lk_in_tcm && m_vld[slot(lk_type, lk_hyp)];
    exp_tgt = exp_hit ? m_tgt[slot(lk_type, lk_hyp)] : 32'h0;
    n_tests++;
    if (lk_hit !== exp_hit || lk_target !== exp_tgt) begin
      n_fail++;
      $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
               tag, lk_hit, lk_target, exp_hit, exp_tgt);
    end
  endtask

  task automatic model_update();
    if (rst || inv_all || cfg_disable) begin
      for (int i = 0; i < 4; i++) m_vld[i] = 0;
    end else if (al_valid && intr(al_type)) begin
      int s;
      bit ok;
      s  = slot(al_type, al_hyp);
      ok = al_in_tcm && al_instr[31:28] == 4'hE && al_instr[27:24] == 4'hA;
      m_vld[s] = ok;
      if (ok)
        m_tgt[s] = al_vaddr + 32'd8 + {{6{al_instr[23]}}, al_instr[23:0], 2'b00};
    end
  endtask

  // inputs are set just after a falling edge; check, then advance one cycle
  task automatic cyc(input string tag);
    #1;
    check(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    lk_valid = 0; al_valid = 0; inv_all = 0;
  endtask

  task automatic look(input logic [1:0] t, input logic h, input logic tcm);
    lk_valid = 1; lk_type = t; lk_hyp = h; lk_in_tcm = tcm;
  endtask

  task automatic put(input logic [1:0] t, input logic h, input logic [31:0] va,
                     input logic [31:0] ins, input logic tcm);
    al_valid = 1; al_type = t; al_hyp = h; al_vaddr = va; al_instr = ins; al_in_tcm = tcm;
  endtask

  task automatic probe_all(input string tag);
    al_valid = 0;
    for (int k = 0; k < 4; k++) begin
      look(k[1] ? 2'b10 : 2'b01, k[0], 1);
      cyc(tag);
    end
    idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_tgt[i] = '0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    probe_all("R7 reset empty");

    // R6: lookup in the allocation cycle sees the old state
    put(2'b01, 0, 32'h0000_0018, 32'hEA00_0010, 1); look(2'b01, 0, 1); cyc("R6 same-cycle alloc");
    idle(); look(2'b01, 0, 1); cyc("R4 R6 forward target");
    put(2'b10, 1, 32'h0000_001C, 32'hEAFF_FFFE, 1); cyc("R4 backward alloc");
    put(2'b01, 1, 32'hFFFF_FFF0, 32'hEA00_0008, 1); cyc("R4 wrap alloc");
    probe_all("R5 independent entries");

    // R1: other types
    idle(); put(2'b00, 0, 32'h100, 32'hEA00_0001, 1); look(2'b00, 0, 1); cyc("R1 other type lookup");
    put(2'b11, 1, 32'h200, 32'hEA00_0002, 1); look(2'b11, 1, 1); cyc("R1 other type lookup");
    probe_all("R1 other type no alloc");

    // R2: tcm flag
    idle(); look(2'b01, 0, 0); cyc("R2 non-tcm lookup");
    put(2'b10, 0, 32'h40, 32'hEA00_0003, 0); cyc("R2 non-tcm alloc");
    probe_all("R2 non-tcm alloc");

    // R3: incompatible words
    put(2'b01, 0, 32'h18, 32'h0A00_0010, 1); cyc("R3 conditional");
    probe_all("R3 conditional clears");
    put(2'b10, 1, 32'h1C, 32'hEB00_0004, 1); cyc("R3 link branch");
    probe_all("R3 link branch clears");

    // R8: disable
    put(2'b10, 0, 32'h80, 32'hEA00_0020, 1); cyc("R8 refill");
    idle(); cfg_disable = 1; look(2'b10, 0, 1); cyc("R8 disabled lookup");
    put(2'b01, 0, 32'h90, 32'hEA00_0001, 1); look(2'b01, 1, 1); cyc("R8 disabled alloc");
    cfg_disable = 0;
    probe_all("R8 after re-enable");

    // R9: invalidate wins over same-cycle allocation
    put(2'b01, 0, 32'h18, 32'hEA00_0010, 1); cyc("R9 refill");
    put(2'b10, 1, 32'h1C, 32'hEA00_0010, 1); look(2'b01, 0, 1); inv_all = 1; cyc("R9 inval cycle");
    probe_all("R9 after inval");

    // R10 and general: biased random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      cfg_disable = (r[3:0] == 4'h0);
      inv_all     = (r[7:4] == 4'h0);
      al_valid = r[8]; al_type = r[10:9]; al_hyp = r[11]; al_in_tcm = (r[13:12] != 2'b00);
      al_vaddr = {$urandom} & 32'hFFFF_FFFC;
      al_instr = r[14] ? {4'hE, 4'hA, 24'($urandom)} : $urandom;
      lk_valid = r[15]; lk_type = r[17:16]; lk_hyp = r[18]; lk_in_tcm = (r[20:19] != 2'b00);
      cyc("R10 random traffic");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule